// File: doc/BRIEF.md
# Protected Control Register Write Sequencer

This block holds a byte-wide control register whose persistent fields (a two-bit watchdog period select, a block-protect flag and a two-bit power-up delay select) can only be changed after a two-step unlock. The unlock uses two volatile latches, a write-enable latch and a register-write-enable latch. A write that changes the fields then starts a busy period, which stands in for the real storage write. The field values drive other logic directly. The stored fields are plain flops that reset to their factory values.

The block sits behind a serial-bus bit engine, which is outside it. That engine reports each bus transaction as a set of pulses. A write starts with `wr_begin`, which carries the target address. Each data byte arrives on `wr_byte_valid`. The stop condition arrives on `wr_end`. For every data byte, the block answers with an acknowledge or a not-acknowledge one cycle later. A control-register write takes effect at its stop, and only if it carried exactly one acknowledged byte. A read request returns the register image one cycle later and changes no state.

Top module: `ctl_reg_seq`

## Requirements
- R1: After reset, both latches are clear, the watchdog select is 11, the power-up select is 01, block-protect is 0 and `busy` is low.
- R2: While the write-enable latch is clear, every data byte to a memory address is not-acknowledged, and so is a control byte other than 00h or 02h. Such bytes change no state.
- R3: A single byte 02h to the control register sets the write-enable latch, and 00h clears it. Both are acknowledged and start no busy period.
- R4: A single byte 06h with the write-enable latch set, but with the register-write-enable latch clear, is acknowledged and sets the register-write-enable latch.
- R5: With both latches set, a single byte whose bit 3 is 0, whose bit 1 is 1 and whose bit 2 is 0 is a commit. It is acknowledged. At the stop, it loads the watchdog select from bits 6:5, block-protect from bit 4, power-up select bit 1 from bit 7 and power-up select bit 0 from bit 0. It also clears the register-write-enable latch, and `busy` is then high for exactly BUSY_CYC cycles. The series 02h, 06h, 02h therefore clears all fields.
- R6: The same pattern with bit 2 set is acknowledged. It keeps the register-write-enable latch set and leaves every field unchanged, with no busy period. The series 02h, 06h, 06h therefore leaves the fields as they were.
- R7: A second data byte in one control-register write is not-acknowledged, and the whole write has no effect.
- R8: While `busy` is high, every data byte is not-acknowledged, and the stop of that write changes nothing.
- R9: One cycle after `rd_req`, `rd_valid` is high. `rd_data` then holds `{pup1, wd[1:0], bp, 0, rwel, wel, pup0}` (bit 7 down to bit 0). A read never changes the latches or the fields.
- R10: When block-protect is set, a data byte to an address from PROT_BASE up to, but not including, CTRL_ADDR is not-acknowledged and clears the register-write-enable latch.
- R11: `ack_valid` is high exactly one cycle after each `wr_byte_valid`. A memory byte is acknowledged only when the write-enable latch is set, the block is not busy and the address is not protected.
- R12: Any other single control byte is not-acknowledged and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_begin | input | 1 | Start of a write transaction |
| wr_addr | input | AW | Target address, sampled with wr_begin |
| wr_byte_valid | input | 1 | One data byte of the current write |
| wr_byte | input | 8 | Data byte |
| wr_end | input | 1 | Stop of the current write |
| rd_req | input | 1 | Read request for the register image |
| ack_valid | output | 1 | Answer to the byte of the previous cycle |
| ack_ok | output | 1 | 1 = acknowledge, 0 = not-acknowledge |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 8 | Register image |
| busy | output | 1 | Commit busy period in progress |
| wd_sel | output | 2 | Watchdog period select |
| bp | output | 1 | Block-protect |
| pup_sel | output | 2 | Power-up delay select |

## Verification
The answer to a byte is due one cycle after the byte, and so is a read result. The latch and field effects of a write appear one cycle after its stop, and `busy` rises in that same cycle. The bench drives every pulse at a falling edge and samples at the next falling edge, so each sample falls exactly one register stage after the stimulus. Busy length is measured by counting the falling edges at which `busy` is high after a commit stop. Random writes wait the busy period out, and one directed case instead probes writes while `busy` is high.

// File: rtl/ctl_reg_seq.sv
module ctl_reg_seq #(
  parameter int unsigned AW = 8,
  parameter logic [AW-1:0] CTRL_ADDR = '1,
  parameter logic [AW-1:0] PROT_BASE = {2'b11, {(AW-2){1'b0}}},
  parameter int unsigned BUSY_CYC = 1000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_begin,
  input  logic [AW-1:0] wr_addr,
  input  logic          wr_byte_valid,
  input  logic [7:0]    wr_byte,
  input  logic          wr_end,
  input  logic          rd_req,
  output logic          ack_valid,
  output logic          ack_ok,
  output logic          rd_valid,
  output logic [7:0]    rd_data,
  output logic          busy,
  output logic [1:0]    wd_sel,
  output logic          bp,
  output logic [1:0]    pup_sel
);
  localparam int CW = $clog2(BUSY_CYC + 1);
  localparam logic [CW-1:0] BUSY_LOAD = CW'(BUSY_CYC);

  typedef enum logic [2:0] {OP_NONE, OP_SET_WE, OP_CLR_WE, OP_ARM, OP_COMMIT, OP_REARM} op_t;

  logic          we_q, arm_q;
  logic [CW-1:0] busy_cnt;
  logic          to_ctrl, to_prot, seen;
  op_t           op_q, op_now;
  logic [7:0]    cmd_q;
  logic          byte_ack;

  function automatic op_t decode(input logic [7:0] d, input logic we, input logic arm);
    if (we && arm && !d[3] && d[1]) return d[2] ? OP_REARM : OP_COMMIT;
    if (d == 8'h02)                 return OP_SET_WE;
    if (d == 8'h00)                 return OP_CLR_WE;
    if (d == 8'h06 && we)           return OP_ARM;
    return OP_NONE;
  endfunction

  assign busy   = busy_cnt != '0;
  assign op_now = decode(wr_byte, we_q, arm_q);
  assign byte_ack = !busy && (to_ctrl ? (!seen && op_now != OP_NONE)
                                      : (we_q && !(to_prot && bp)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      to_ctrl <= 1'b0;
      to_prot <= 1'b0;
      seen    <= 1'b0;
      op_q    <= OP_NONE;
      cmd_q   <= '0;
    end else if (wr_begin) begin
      to_ctrl <= wr_addr == CTRL_ADDR;
      to_prot <= wr_addr >= PROT_BASE && wr_addr != CTRL_ADDR;
      seen    <= 1'b0;
      op_q    <= OP_NONE;
    end else if (wr_byte_valid && to_ctrl) begin
      seen  <= 1'b1;
      op_q  <= byte_ack ? op_now : OP_NONE;
      cmd_q <= wr_byte;
    end else if (wr_end) begin
      op_q <= OP_NONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_valid <= 1'b0;
      ack_ok    <= 1'b0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
    end else begin
      ack_valid <= wr_byte_valid;
      ack_ok    <= wr_byte_valid && byte_ack;
      rd_valid  <= rd_req;
      if (rd_req) rd_data <= {pup_sel[1], wd_sel, bp, 1'b0, arm_q, we_q, pup_sel[0]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q     <= 1'b0;
      arm_q    <= 1'b0;
      wd_sel   <= 2'b11;
      bp       <= 1'b0;
      pup_sel  <= 2'b01;
      busy_cnt <= '0;
    end else begin
      if (busy) busy_cnt <= busy_cnt - 1'b1;
      if (wr_byte_valid && !to_ctrl && to_prot && bp) arm_q <= 1'b0;
      if (wr_end && to_ctrl && !busy) begin
        unique case (op_q)
          OP_SET_WE: we_q <= 1'b1;
          OP_CLR_WE: we_q <= 1'b0;
          OP_ARM:    arm_q <= 1'b1;
          OP_REARM:  arm_q <= 1'b1;
          OP_COMMIT: begin
            arm_q    <= 1'b0;
            wd_sel   <= cmd_q[6:5];
            bp       <= cmd_q[4];
            pup_sel  <= {cmd_q[7], cmd_q[0]};
            busy_cnt <= BUSY_LOAD;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/ctl_reg_seq_chk.sv
module ctl_reg_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_byte_valid,
  input logic       wr_end,
  input logic       rd_req,
  input logic       ack_valid,
  input logic       ack_ok,
  input logic       rd_valid,
  input logic       busy,
  input logic [1:0] wd_sel,
  input logic       bp,
  input logic [1:0] pup_sel
);
  p_ack_follows_byte_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_byte_valid |=> ack_valid);
  p_ack_has_byte_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> $past(wr_byte_valid));
  p_busy_nack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_byte_valid) |=> (ack_valid && !ack_ok));
  p_fields_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_end) |-> ($stable(wd_sel) && $stable(bp) && $stable(pup_sel)));
  p_busy_after_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wr_end));
  p_read_answer_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid);
endmodule

bind ctl_reg_seq ctl_reg_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .wr_byte_valid(wr_byte_valid), .wr_end(wr_end),
  .rd_req(rd_req), .ack_valid(ack_valid), .ack_ok(ack_ok), .rd_valid(rd_valid),
  .busy(busy), .wd_sel(wd_sel), .bp(bp), .pup_sel(pup_sel)
);

// File: tb/ctl_reg_seq_tb_top.sv
module ctl_reg_seq_tb_top;
  localparam int unsigned BUSY_T = 20;
  localparam logic [7:0] CTRL = 8'hFF;
  localparam logic [7:0] PBASE = 8'hC0;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_begin = 0, wr_byte_valid = 0, wr_end = 0, rd_req = 0;
  logic [7:0] wr_addr = 0, wr_byte = 0;
  logic ack_valid, ack_ok, rd_valid, busy, bp;
  logic [7:0] rd_data;
  logic [1:0] wd_sel, pup_sel;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  ctl_reg_seq #(.AW(8), .CTRL_ADDR(CTRL), .PROT_BASE(PBASE), .BUSY_CYC(BUSY_T)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_begin(wr_begin), .wr_addr(wr_addr),
    .wr_byte_valid(wr_byte_valid), .wr_byte(wr_byte), .wr_end(wr_end), .rd_req(rd_req),
    .ack_valid(ack_valid), .ack_ok(ack_ok), .rd_valid(rd_valid), .rd_data(rd_data),
    .busy(busy), .wd_sel(wd_sel), .bp(bp), .pup_sel(pup_sel));

  logic m_we = 0, m_arm = 0, m_bp = 0;
  logic [1:0] m_wd = 2'b11, m_pup = 2'b01;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] m_image();
    return {m_pup[1], m_wd, m_bp, 1'b0, m_arm, m_we, m_pup[0]};
  endfunction

  // 0 none, 1 set we, 2 clr we, 3 arm, 4 commit, 5 rearm
  function automatic int m_decode(input logic [7:0] d);
    if (m_we && m_arm && !d[3] && d[1]) return d[2] ? 5 : 4;
    if (d == 8'h02) return 1;
    if (d == 8'h00) return 2;
    if (d == 8'h06 && m_we) return 3;
    return 0;
  endfunction

  task automatic pulse_begin(input logic [7:0] a);
    @(negedge clk); wr_begin = 1; wr_addr = a;
    @(negedge clk); wr_begin = 0;
  endtask

  task automatic send_byte(input logic [7:0] d, input bit exp, input string req);
    @(negedge clk); wr_byte_valid = 1; wr_byte = d;
    @(negedge clk); wr_byte_valid = 0;
    chk(ack_valid && ack_ok == exp, req, {ack_valid, ack_ok}, {1'b1, exp});
  endtask

  task automatic pulse_end();
    @(negedge clk); wr_end = 1;
    @(negedge clk); wr_end = 0;
  endtask

  task automatic check_fields(input string req);
    chk(wd_sel == m_wd && bp == m_bp && pup_sel == m_pup, req,
        {wd_sel, bp, pup_sel}, {m_wd, m_bp, m_pup});
  endtask

  task automatic do_read(input string req);
    @(negedge clk); rd_req = 1;
    @(negedge clk); rd_req = 0;
    chk(rd_valid && rd_data == m_image(), req, {rd_valid, rd_data}, {1'b1, m_image()});
  endtask

  task automatic wait_busy(input bit expect_busy);
    int n = 0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
    chk(n == (expect_busy ? BUSY_T : 0), "R5 busy length", n, expect_busy ? BUSY_T : 0);
  endtask

  task automatic ctrl_write(input logic [7:0] d);
    int op = m_decode(d);
    bit commit = 0;
    pulse_begin(CTRL);
    send_byte(d, op != 0, op == 0 ? "R12 ctrl nack" : "R3 R4 R5 R6 ctrl ack");
    pulse_end();
    case (op)
      1: m_we = 1;
      2: m_we = 0;
      3: m_arm = 1;
      5: m_arm = 1;
      4: begin m_arm = 0; m_wd = d[6:5]; m_bp = d[4]; m_pup = {d[7], d[0]}; commit = 1; end
      default: ;
    endcase
    check_fields("R5 R6 fields after stop");
    wait_busy(commit);
  endtask

  task automatic ctrl_double(input logic [7:0] d0, input logic [7:0] d1);
    int op = m_decode(d0);
    pulse_begin(CTRL);
    send_byte(d0, op != 0, "R7 first byte");
    send_byte(d1, 1'b0, "R7 second byte nack");
    pulse_end();
    check_fields("R7 abort fields");
    wait_busy(1'b0);
  endtask

  task automatic mem_write(input logic [7:0] a, input int n);
    bit prot = (a >= PBASE) && (a != CTRL) && m_bp;
    pulse_begin(a);
    for (int i = 0; i < n; i++) begin
      send_byte(8'($urandom), m_we && !prot, prot ? "R10 protected nack" : "R2 R11 memory byte");
      if (prot) m_arm = 0;
    end
    pulse_end();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h1c3d));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_fields("R1 reset fields");
    chk(!busy && !ack_valid, "R1 reset busy", busy, 0);
    do_read("R1 R9 reset image");

    // R2: latch clear blocks writes
    mem_write(8'h10, 2);
    ctrl_write(8'h06);
    ctrl_write(8'h12);
    do_read("R2 state unchanged");
    // R3
    ctrl_write(8'h02);
    do_read("R3 we set");
    ctrl_write(8'h00);
    do_read("R3 we cleared");
    // R5 series 02 06 02 clears fields, with a read between (R9)
    ctrl_write(8'h02);
    ctrl_write(8'h06);
    do_read("R9 read mid sequence");
    ctrl_write(8'h02);
    chk(wd_sel == 0 && bp == 0 && pup_sel == 0, "R5 02 06 02 clears", {wd_sel, bp, pup_sel}, 0);
    do_read("R5 arm cleared after commit");
    // R6 series 02 06 06
    ctrl_write(8'h06);
    ctrl_write(8'h06);
    chk(wd_sel == 0 && pup_sel == 0, "R6 fields kept", {wd_sel, pup_sel}, 0);
    do_read("R6 arm still set");
    // R5 commit with field mapping
    ctrl_write(8'hD3);
    chk(wd_sel == 2'b10 && bp == 1 && pup_sel == 2'b11, "R5 field map", {wd_sel, bp, pup_sel}, 8'h17);
    // R7 abort
    ctrl_write(8'h06);
    ctrl_double(8'h22, 8'h02);
    do_read("R7 arm untouched");
    // R10 protected write clears arm
    mem_write(8'hC5, 1);
    do_read("R10 arm cleared");
    mem_write(8'h20, 1);
    // R8 busy window
    ctrl_write(8'h06);
    pulse_begin(CTRL);
    send_byte(8'h02, 1'b1, "R5 commit ack");
    pulse_end();
    m_arm = 0; m_wd = 0; m_bp = 0; m_pup = 0;
    chk(busy, "R5 busy rises", busy, 1);
    pulse_begin(CTRL);
    send_byte(8'h00, 1'b0, "R8 busy ctrl nack");
    pulse_end();
    pulse_begin(8'h05);
    send_byte(8'h55, 1'b0, "R8 busy mem nack");
    pulse_end();
    begin : wait_out
      int n = 0;
      while (busy && n < 1000) begin n++; @(negedge clk); end
    end
    do_read("R8 no effect from busy writes");

    // random phase
    for (int it = 0; it < 400; it++) begin
      int k = $urandom_range(0, 9);
      logic [7:0] d = 8'($urandom);
      case (k)
        0: do_read("R9 random read");
        1, 2: ctrl_write(8'h02);
        3: ctrl_write(8'h06);
        4: ctrl_write({d[7:4], 1'b0, d[2], 1'b1, d[0]});
        5: ctrl_write(d);
        6: ctrl_write(8'h00);
        7: ctrl_double(($urandom_range(0, 1) != 0) ? 8'h02 : d, 8'($urandom));
        default: mem_write(($urandom_range(0, 1) != 0) ? 8'($urandom_range(8'hC0, 8'hFE)) : 8'($urandom_range(0, 8'hBF)),
                           $urandom_range(1, 3));
      endcase
    end
    do_read("R9 final image");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule